// File: doc/BRIEF.md
# RDS Bit Buffer with Dual-Mode Readout

This block sits behind an RDS demodulator and stores the decoded data bits, each paired with a reliability flag, in a 128-entry FIFO that holds roughly 100 ms of traffic. The FIFO is drained towards a host in one of two ways. In master mode the block generates its own bit clock at the RDS bit rate and presents each bit for the host to sample on the falling clock edge. In slave mode the host drives the clock and takes one bit per clock edge, guided by a READY indication.

A clear input re-arms the block when the receiver retunes. After a clear or a reset, nothing is stored until the demodulator first reports a valid RDS signal. From then on bits are kept even if the signal is later lost. Bits leave the FIFO only when they are delivered, so the readout mode can be changed between bits without losing or repeating one.

The bidirectional bit clock pin is modelled as a clock output, an output enable and a clock input.

Top module: `rds_bitbuf`

## Requirements
- R1: `{test_sel, mode_sel}` selects the operating mode. 2'b00 is master: `bclk_oe`=1. 2'b01 is slave: `bclk_oe`=0. 2'b10 is standby and 2'b11 is reserved test. In both of those `bclk_oe`=0, `dat_o`=1 and `stat_o`=0, and the block neither stores bits nor arms.
- R2: After reset or a clear pulse, a `bit_stb` is stored only if `sig_det` is high in the same cycle or was high in an earlier cycle since the clear. Once armed, bits are stored while `sig_det` is low.
- R3: The FIFO holds 128 bits. A store while it is full discards the oldest bit, so after 130 stores the readout returns stores 3 to 130.
- R4: In slave mode `stat_o` is READY. It is high when at least one bit is stored, becomes high in the cycle after the storing clock edge, and falls once the last bit has been read.
- R5: In slave mode every edge of `host_clk` (rising or falling) removes the bit shown on `dat_o`. The next bit appears exactly 3 system clock cycles after the input changes, and is not visible in the cycle before.
- R6: A clear pulse in slave mode empties the FIFO, drops READY and disarms storage.
- R7: In master mode, while bits are available, `bclk_o` is high for HALF_CYC cycles and low for HALF_CYC cycles. `dat_o` and `stat_o` (the bit's reliability flag) change DATA_DLY cycles after the rising edge and carry one stored bit, in order, per clock period.
- R8: In master mode, while the block is not armed (after reset or a clear), `bclk_o` and `dat_o` are held high.
- R9: In master mode, if the FIFO is empty when a bit period would start, `bclk_o` stays high until a bit is stored.
- R10: Switching from master to slave right after the falling clock edge of bit n presents bit n+1 first in slave mode, so the sequence is unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rds_clr | input | 1 | Clear: disarm, and empty the FIFO in slave mode |
| test_sel | input | 1 | Mode select, upper bit |
| mode_sel | input | 1 | Mode select, lower bit (0 master, 1 slave) |
| bit_stb | input | 1 | One-cycle strobe for a decoded bit |
| bit_val | input | 1 | Decoded data bit |
| bit_rel | input | 1 | Reliability flag of the decoded bit |
| sig_det | input | 1 | Demodulator reports a valid RDS signal |
| host_clk | input | 1 | Readout clock from host (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| dat_o | output | 1 | Bit data to host |
| stat_o | output | 1 | Reliability (master) or READY (slave) |

## Verification
READY is due one cycle after the edge that stores a bit, so the bench samples on the falling system clock edge right after each strobe. In slave mode a host clock change passes through two synchronizer flops before the pop takes effect. The bench therefore checks that the old bit is still shown one cycle after the change and that the new bit appears on the third cycle. In master mode a monitor counts falling-edge samples: each low phase must last HALF_CYC samples, and data must change on the DATA_DLY-th sample after a rising edge. Bits are captured at each falling edge of `bclk_o`, and the mode switch is made in that same sample so that it lands before the next pop.

// File: rtl/rds_bitbuf_pkg.sv
package rds_bitbuf_pkg;

  typedef enum logic [1:0] {
    OP_MASTER  = 2'b00,
    OP_SLAVE   = 2'b01,
    OP_STANDBY = 2'b10,
    OP_TEST    = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic dat;
    logic rel;
  } rds_bit_t;

  function automatic op_mode_e decode_mode(input logic test_sel, input logic mode_sel);
    return op_mode_e'({test_sel, mode_sel});
  endfunction

  // Clock level of the generated bit clock for a given phase of the period.
  function automatic logic phase_is_high(input int unsigned phase, input int unsigned half);
    return phase < half;
  endfunction

  // Next phase of the bit period, wrapping after two half periods.
  function automatic int unsigned phase_next(input int unsigned phase, input int unsigned half);
    return (phase == 2 * half - 1) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/rds_bitbuf_fifo.sv
module rds_bitbuf_fifo
  import rds_bitbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  rds_bit_t      wr_data,
  input  logic          rd_en,
  output rds_bit_t      rd_data,
  output logic [CW-1:0] level,
  output logic          empty
);

  rds_bit_t      mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, drop_old, rp_adv;

  assign full     = (level == CW'(DEPTH));
  assign empty    = (level == '0);
  assign drop_old = wr_en && full && !rd_en;
  assign rp_adv   = rd_en || drop_old;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_en)  wp <= wp + 1'b1;
      if (rp_adv) rp <= rp + 1'b1;
      if (wr_en && !rd_en && !full) level <= level + 1'b1;
      else if (rd_en && !wr_en)     level <= level - 1'b1;
    end
  end

  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  p_full_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> (level == CW'(DEPTH)));

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/rds_bitbuf_host.sv
module rds_bitbuf_host (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic host_clk,
  output logic edge_seen
);

  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= host_clk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_seen = enable && (s2 ^ s3);

endmodule

// File: rtl/rds_bitbuf_pacer.sv
module rds_bitbuf_pacer
  import rds_bitbuf_pkg::*;
#(
  parameter int HALF_CYC = 21053,
  parameter int DATA_DLY = 850,
  localparam int PW = $clog2(2 * HALF_CYC)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     have_bit,
  input  rds_bit_t head,
  output logic     pop,
  output logic     bclk,
  output logic     dat,
  output logic     rel
);

  logic [PW-1:0] phase;
  logic          stall;

  assign stall = (phase == '0) && !have_bit;
  assign pop   = active && (phase == PW'(DATA_DLY - 1));
  assign bclk  = !active || phase_is_high(32'(phase), HALF_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      dat   <= 1'b1;
      rel   <= 1'b0;
    end else if (!active) begin
      phase <= '0;
      dat   <= 1'b1;
      rel   <= 1'b0;
    end else begin
      if (!stall) phase <= PW'(phase_next(32'(phase), HALF_CYC));
      if (pop) begin
        dat <= head.dat;
        rel <= head.rel;
      end
    end
  end

  p_pop_has_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> have_bit);

  p_idle_data_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> dat);

  p_stall_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stall) |=> (!active || bclk));

endmodule

// File: rtl/rds_bitbuf.sv
module rds_bitbuf
  import rds_bitbuf_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int HALF_CYC = 21053,
  parameter int DATA_DLY = 850,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rds_clr,
  input  logic test_sel,
  input  logic mode_sel,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic bit_rel,
  input  logic sig_det,
  input  logic host_clk,
  output logic bclk_o,
  output logic bclk_oe,
  output logic dat_o,
  output logic stat_o
);

  op_mode_e      op;
  logic          is_master, is_slave, running;
  logic          armed, arm_now;
  logic          wr_en, rd_en, flush;
  logic          pop_m, pop_s, host_edge;
  logic          empty;
  logic [CW-1:0] level;
  rds_bit_t      head, in_bit;
  logic          m_clk, m_dat, m_rel, m_active;

  assign op        = decode_mode(test_sel, mode_sel);
  assign is_master = (op == OP_MASTER);
  assign is_slave  = (op == OP_SLAVE);
  assign running   = is_master || is_slave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (rds_clr)            armed <= 1'b0;
    else if (running && sig_det) armed <= 1'b1;
  end

  assign arm_now = armed || sig_det;
  assign wr_en   = bit_stb && running && !rds_clr && arm_now;
  assign flush   = rds_clr && is_slave;
  assign in_bit  = '{dat: bit_val, rel: bit_rel};

  assign pop_s = is_slave && host_edge && !empty;
  assign rd_en = pop_m || pop_s;

  rds_bitbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .wr_en  (wr_en),
    .wr_data(in_bit),
    .rd_en  (rd_en),
    .rd_data(head),
    .level  (level),
    .empty  (empty)
  );

  rds_bitbuf_host u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (is_slave),
    .host_clk (host_clk),
    .edge_seen(host_edge)
  );

  assign m_active = is_master && armed && !rds_clr;

  rds_bitbuf_pacer #(.HALF_CYC(HALF_CYC), .DATA_DLY(DATA_DLY)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (m_active),
    .have_bit(!empty),
    .head    (head),
    .pop     (pop_m),
    .bclk    (m_clk),
    .dat     (m_dat),
    .rel     (m_rel)
  );

  always_comb begin
    unique case (op)
      OP_MASTER: begin dat_o = m_dat;    stat_o = m_rel;  end
      OP_SLAVE:  begin dat_o = head.dat; stat_o = !empty; end
      default:   begin dat_o = 1'b1;     stat_o = 1'b0;   end
    endcase
  end

  assign bclk_oe = is_master;
  assign bclk_o  = is_master ? m_clk : 1'b1;

  p_standby_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(level));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !sig_det && !armed && !rd_en && !flush) |=> $stable(level));

  p_ready_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_slave) |=> (!is_slave || stat_o));

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

endmodule

// File: tb/rds_bitbuf_tb.sv
module rds_bitbuf_tb;

  localparam int HALF = 8;
  localparam int DLY  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rds_clr = 1'b0, test_sel = 1'b0, mode_sel = 1'b1;
  logic bit_stb = 1'b0, bit_val = 1'b0, bit_rel = 1'b0, sig_det = 1'b0;
  logic host_clk = 1'b0;
  logic bclk_o, bclk_oe, dat_o, stat_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rds_bitbuf #(.DEPTH(128), .HALF_CYC(HALF), .DATA_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .rds_clr(rds_clr), .test_sel(test_sel),
    .mode_sel(mode_sel), .bit_stb(bit_stb), .bit_val(bit_val),
    .bit_rel(bit_rel), .sig_det(sig_det), .host_clk(host_clk),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .dat_o(dat_o), .stat_o(stat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic v, input logic r, input logic det);
    bit_stb = 1'b1; bit_val = v; bit_rel = r; sig_det = det;
    tick();
    bit_stb = 1'b0; sig_det = 1'b0;
  endtask

  task automatic clear_slave();
    test_sel = 1'b0; mode_sel = 1'b1;
    rds_clr = 1'b1; tick();
    rds_clr = 1'b0; tick();
  endtask

  task automatic host_toggle();
    host_clk = ~host_clk;
    repeat (4) tick();
  endtask

  function automatic logic pv(input int i);
    return ((i * 5) % 7) > 3;
  endfunction

  task automatic t_reset();
    chk("R4 reset READY", stat_o, 0);
    chk("R1 slave oe", bclk_oe, 0);
  endtask

  task automatic t_gate();
    clear_slave();
    repeat (3) push(1'b0, 1'b0, 1'b0);
    chk("R2 no store before detect", stat_o, 0);
    push(1'b1, 1'b0, 1'b1);
    chk("R2 store on detect", stat_o, 1);
    push(1'b0, 1'b0, 1'b0);
    push(1'b1, 1'b0, 1'b0);
    chk("R2 bit0", dat_o, 1); host_toggle();
    chk("R2 bit1", dat_o, 0); host_toggle();
    chk("R2 bit2", dat_o, 1); host_toggle();
    chk("R4 READY falls after last", stat_o, 0);
  endtask

  task automatic t_ready();
    clear_slave();
    chk("R4 empty READY", stat_o, 0);
    push(1'b1, 1'b1, 1'b1);
    chk("R4 READY next cycle", stat_o, 1);
    host_toggle();
    chk("R4 READY low after read", stat_o, 0);
  endtask

  task automatic t_overflow();
    int bad = 0;
    clear_slave();
    for (int i = 0; i < 130; i++) push(pv(i), 1'b0, 1'b1);
    for (int i = 2; i < 130; i++) begin
      if (dat_o !== pv(i)) begin
        bad++;
        $display("FAIL R3 bit %0d: got %0d expected %0d", i, dat_o, pv(i));
      end
      host_toggle();
    end
    n_chk++;
    if (bad != 0) n_bad++;
    chk("R3 drained after 128", stat_o, 0);
  endtask

  task automatic t_edges();
    clear_slave();
    push(1'b1, 1'b0, 1'b1);
    push(1'b0, 1'b0, 1'b0);
    push(1'b0, 1'b0, 1'b0);
    push(1'b1, 1'b0, 1'b0);
    chk("R5 first", dat_o, 1);
    host_clk = ~host_clk;
    tick();
    chk("R5 old bit 1 cycle after", dat_o, 1);
    tick(); tick();
    chk("R5 new bit at 3 cycles", dat_o, 0);
    tick();
    host_toggle();
    chk("R5 third after second edge", dat_o, 0);
    host_toggle();
    chk("R5 fourth", dat_o, 1);
    host_toggle();
    chk("R5 empty", stat_o, 0);
  endtask

  task automatic t_clear();
    clear_slave();
    for (int i = 0; i < 5; i++) push(1'b1, 1'b0, 1'b1);
    chk("R6 filled", stat_o, 1);
    rds_clr = 1'b1; tick(); rds_clr = 1'b0; tick();
    chk("R6 READY after clear", stat_o, 0);
    push(1'b1, 1'b0, 1'b0);
    chk("R6 disarmed", stat_o, 0);
  endtask

  task automatic t_standby();
    clear_slave();
    test_sel = 1'b1; mode_sel = 1'b0; tick();
    chk("R1 standby oe", bclk_oe, 0);
    chk("R1 standby dat", dat_o, 1);
    chk("R1 standby stat", stat_o, 0);
    push(1'b0, 1'b0, 1'b1);
    test_sel = 1'b1; mode_sel = 1'b1; tick();
    chk("R1 test mode oe", bclk_oe, 0);
    push(1'b0, 1'b0, 1'b1);
    test_sel = 1'b0; mode_sel = 1'b1; tick();
    chk("R1 nothing stored in standby", stat_o, 0);
  endtask

  task automatic master_capture(input int nbits, output logic [7:0] dq, output logic [7:0] rq);
    logic pc = bclk_o;
    logic pd = dat_o;
    logic pr = stat_o;
    int hi = 0, lo = 0, got = 0, lim = 0;
    bit fell = 0, rose = 0;
    dq = '0; rq = '0;
    while (got < nbits && lim < 40 * HALF * (nbits + 1)) begin
      tick(); lim++;
      if (bclk_o) begin
        if (!pc) begin
          if (fell) chk("R7 low length", lo, HALF);
          hi = 0; rose = fell;
        end else hi++;
        if ((dat_o !== pd || stat_o !== pr) && rose) chk("R7 data delay", hi, DLY);
      end else begin
        if (pc) begin
          if (rose) chk("R7 high length", hi + 1, HALF);
          dq[got] = dat_o; rq[got] = stat_o; got++;
          lo = 1; fell = 1;
        end else lo++;
      end
      pc = bclk_o; pd = dat_o; pr = stat_o;
    end
    if (got < nbits) chk("R7 master bits delivered", got, nbits);
  endtask

  task automatic t_master();
    logic [5:0] ed = 6'b001101;
    logic [5:0] er = 6'b010110;
    logic [7:0] dq, rq;
    clear_slave();
    test_sel = 1'b0; mode_sel = 1'b0; tick();
    chk("R1 master oe", bclk_oe, 1);
    for (int i = 0; i < 4; i++) push(1'b0, 1'b0, 1'b0);
    chk("R8 idle clock high", bclk_o, 1);
    chk("R8 idle data high", dat_o, 1);
    for (int i = 0; i < 6; i++) push(ed[i], er[i], i == 0);
    master_capture(3, dq, rq);
    mode_sel = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R7 master data", dq[i], ed[i]);
      chk("R7 master reliability", rq[i], er[i]);
    end
    tick();
    for (int i = 3; i < 6; i++) begin
      chk("R10 continuity in slave", dat_o, ed[i]);
      host_toggle();
    end
    chk("R10 all read", stat_o, 0);
    mode_sel = 1'b0;
    begin
      int low_seen = 0;
      for (int i = 0; i < 5 * HALF; i++) begin
        tick();
        if (!bclk_o) low_seen++;
      end
      chk("R9 stall high while empty", low_seen, 0);
    end
    push(1'b0, 1'b1, 1'b0);
    master_capture(1, dq, rq);
    chk("R9 resumes, R2 stays armed data", dq[0], 0);
    chk("R9 resumes reliability", rq[0], 1);
    rds_clr = 1'b1; tick(); rds_clr = 1'b0;
    push(1'b0, 1'b0, 1'b0);
    begin
      int low_seen = 0;
      for (int i = 0; i < 4 * HALF; i++) begin
        tick();
        if (!bclk_o || !dat_o) low_seen++;
      end
      chk("R8 high after clear", low_seen, 0);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_gate();
    t_ready();
    t_edges();
    t_clear();
    t_standby();
    t_overflow();
    t_master();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule